// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a page table that has two levels and lives in memory. A requester presents a virtual address together with the physical base of the first-level table. The walker then makes word reads over a simple request/response memory port. At the end it reports either the translated physical address or a page fault, and the fault says which level of the walk stopped it.

The address splits into three fields:

- **Top ten bits:** the index into the first-level table.
- **Next ten bits:** the index into the second-level table.
- **Low twelve bits:** the offset within a 4 KB page. This field is passed through unchanged.

Each table entry is one 4-byte word, so every index is multiplied by four before it is added to a base. Bit 0 of every entry is the valid bit.

- In a first-level entry, the whole word with bit 0 cleared gives the physical start of the second-level table.
- In a second-level entry, bits 31:12 give the page frame number.

A second-level table may not be resident. Its first-level entry then carries valid = 0, and the walk stops with a fault at the first level.

Top module: `ptw_walker`

## Requirements
- R1: While `rst` is high, and in the cycle after it, the walker is idle: `busy`, `done` and `mem_req_valid` are low and `req_ready` is high. A reset in the middle of a walk drops that walk, and no `done` pulse follows.
- R2: A request is taken only in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low for the whole walk, and a `req_valid` raised during a walk has no effect on the read addresses or on the result.
- R3: The first memory read of a walk uses the address `tbl_base + 4 * vaddr[31:22]`, with `tbl_base` sampled when the request is taken.
- R4: If the first-level entry has bit 0 = 0, the walk ends after one read. `done` pulses with `fault` = 1 and `fault_level` = 0.
- R5: If the first-level entry E1 has bit 0 = 1, the second read uses the address `(E1 with bit 0 cleared) + 4 * vaddr[21:12]`.
- R6: If the second-level entry has bit 0 = 0, `done` pulses with `fault` = 1 and `fault_level` = 1.
- R7: If the second-level entry E2 has bit 0 = 1, `done` pulses with `fault` = 0 and `paddr` = {E2[31:12], vaddr[11:0]}.
- R8: A memory request keeps `mem_req_valid` high and `mem_req_addr` stable until `mem_req_ready` is high. No new request is made while a read is awaiting its response.
- R9: `done` is high for exactly one cycle per walk. `busy` is high from the cycle after acceptance up to the cycle in which `done` rises.
- R10: A walk that succeeds makes exactly two memory reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| tbl_base | input | 32 | Physical base of the first-level table |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Table entry that was read |
| done | output | 1 | One-cycle end-of-walk pulse |
| fault | output | 1 | Walk ended in a page fault |
| fault_level | output | 1 | Level that faulted: 0 = first, 1 = second |
| paddr | output | 32 | Translated physical address |

## Verification
The assertions take for granted that memory sends exactly one response for each accepted request. They also assume that no response comes in a cycle when the walker is not waiting for one, and that `rst` is held high from time zero. The bench memory model follows these rules by construction:

- It answers only after a handshake.
- It answers after a latency that can be set.
- It clears any pending response on reset.

Request-side backpressure comes from a stall count that holds `mem_req_ready` low for a chosen number of cycles before each request is taken.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int ADDR_BITS = 32;
  localparam int PAGE_OFF_BITS = 12;
  localparam int LVL_IDX_BITS = 10;
  localparam int ENTRY_BYTES = 4;

  typedef enum logic [2:0] {
    WK_IDLE,
    WK_L1_REQ,
    WK_L1_WAIT,
    WK_L2_REQ,
    WK_L2_WAIT
  } walk_state_e;
endpackage

// File: rtl/ptw_va_split.sv
module ptw_va_split #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10
) (
  input  logic [ADDR_W-1:0] va,
  output logic [IDX_W-1:0]  hi_idx,
  output logic [IDX_W-1:0]  lo_idx,
  output logic [OFF_W-1:0]  pg_off
);
  localparam int LO_TOP = OFF_W + IDX_W;

  assign pg_off = va[OFF_W-1:0];
  assign lo_idx = va[LO_TOP-1:OFF_W];
  assign hi_idx = va[ADDR_W-1:LO_TOP];
endmodule

// File: rtl/ptw_walk_ctrl.sv
module ptw_walk_ctrl
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10,
  parameter int PTE_B  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [ADDR_W-1:0] tbl_base,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              done,
  output logic              fault,
  output logic              fault_level,
  output logic [ADDR_W-1:0] paddr,
  output logic [ADDR_W-1:0] va_q,
  input  logic [IDX_W-1:0]  hi_idx,
  input  logic [IDX_W-1:0]  lo_idx,
  input  logic [OFF_W-1:0]  pg_off
);
  localparam int PTE_SHIFT = $clog2(PTE_B);

  function automatic logic [ADDR_W-1:0] entry_addr(input logic [ADDR_W-1:0] base,
                                                    input logic [IDX_W-1:0]  idx);
    logic [ADDR_W-1:0] scaled;
    scaled = ADDR_W'(idx) << PTE_SHIFT;
    return base + scaled;
  endfunction

  function automatic logic [ADDR_W-1:0] next_table(input logic [ADDR_W-1:0] e);
    return {e[ADDR_W-1:1], 1'b0};
  endfunction

  function automatic logic [ADDR_W-1:0] join_pa(input logic [ADDR_W-1:0] e,
                                                 input logic [OFF_W-1:0]  off);
    return {e[ADDR_W-1:OFF_W], off};
  endfunction

  walk_state_e       state;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] l2_base_q;

  logic ev_accept, ev_l1_rsp, ev_l2_rsp, ev_req_fire;
  assign ev_accept   = req_valid && (state == WK_IDLE);
  assign ev_l1_rsp   = (state == WK_L1_WAIT) && mem_rsp_valid;
  assign ev_l2_rsp   = (state == WK_L2_WAIT) && mem_rsp_valid;
  assign ev_req_fire = mem_req_valid && mem_req_ready;

  assign req_ready     = (state == WK_IDLE);
  assign busy          = (state != WK_IDLE);
  assign mem_req_valid = (state == WK_L1_REQ) || (state == WK_L2_REQ);
  assign mem_req_addr  = (state == WK_L2_REQ) ? entry_addr(l2_base_q, lo_idx)
                                              : entry_addr(base_q, hi_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= WK_IDLE;
      va_q        <= '0;
      base_q      <= '0;
      l2_base_q   <= '0;
      done        <= 1'b0;
      fault       <= 1'b0;
      fault_level <= 1'b0;
      paddr       <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        WK_IDLE: if (ev_accept) begin
          va_q   <= req_vaddr;
          base_q <= tbl_base;
          state  <= WK_L1_REQ;
        end
        WK_L1_REQ: if (ev_req_fire) state <= WK_L1_WAIT;
        WK_L1_WAIT: if (ev_l1_rsp) begin
          if (mem_rsp_data[0]) begin
            l2_base_q <= next_table(mem_rsp_data);
            state     <= WK_L2_REQ;
          end else begin
            done        <= 1'b1;
            fault       <= 1'b1;
            fault_level <= 1'b0;
            state       <= WK_IDLE;
          end
        end
        WK_L2_REQ: if (ev_req_fire) state <= WK_L2_WAIT;
        WK_L2_WAIT: if (ev_l2_rsp) begin
          done        <= 1'b1;
          fault       <= ~mem_rsp_data[0];
          fault_level <= 1'b1;
          if (mem_rsp_data[0]) paddr <= join_pa(mem_rsp_data, pg_off);
          state <= WK_IDLE;
        end
        default: state <= WK_IDLE;
      endcase
    end
  end

  a_r1_idle_after_reset: assert property (@(posedge clk)
    rst |=> (!busy && !done && !mem_req_valid && req_ready));

  a_r2_ignore_when_busy: assert property (@(posedge clk) disable iff (rst)
    (req_valid && busy) |=> $stable(va_q));

  a_r4_l1_fault: assert property (@(posedge clk) disable iff (rst)
    (ev_l1_rsp && !mem_rsp_data[0]) |=> (done && fault && !fault_level && !mem_req_valid));

  a_r6_l2_fault: assert property (@(posedge clk) disable iff (rst)
    (ev_l2_rsp && !mem_rsp_data[0]) |=> (done && fault && fault_level));

  a_r7_offset_pass: assert property (@(posedge clk) disable iff (rst)
    (ev_l2_rsp && mem_rsp_data[0]) |=> (done && !fault && paddr[OFF_W-1:0] == $past(va_q[OFF_W-1:0])));

  a_r8_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  a_r8_no_req_after_fire: assert property (@(posedge clk) disable iff (rst)
    ev_req_fire |=> !mem_req_valid);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int ADDR_W = ADDR_BITS,
  parameter int OFF_W  = PAGE_OFF_BITS,
  parameter int IDX_W  = LVL_IDX_BITS,
  parameter int PTE_B  = ENTRY_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [ADDR_W-1:0] tbl_base,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              done,
  output logic              fault,
  output logic              fault_level,
  output logic [ADDR_W-1:0] paddr
);
  logic [ADDR_W-1:0] va_q;
  logic [IDX_W-1:0]  hi_idx, lo_idx;
  logic [OFF_W-1:0]  pg_off;

  ptw_va_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) split_i (
    .va(va_q), .hi_idx(hi_idx), .lo_idx(lo_idx), .pg_off(pg_off)
  );

  ptw_walk_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .PTE_B(PTE_B)) ctrl_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .tbl_base(tbl_base),
    .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .fault(fault), .fault_level(fault_level), .paddr(paddr),
    .va_q(va_q), .hi_idx(hi_idx), .lo_idx(lo_idx), .pg_off(pg_off)
  );
endmodule

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [31:0] req_vaddr = '0, tbl_base = '0;
  logic req_ready, busy, mem_req_valid, mem_req_ready, done, fault, fault_level;
  logic [31:0] mem_req_addr, paddr;
  logic mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  always #2 clk = ~clk;

  ptw_walker dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .tbl_base(tbl_base), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .fault(fault), .fault_level(fault_level), .paddr(paddr)
  );

  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] mem [logic [31:0]];
  int lat_cfg = 0, stall_cfg = 0, stall_ctr = 0, wait_ctr = 0;
  logic pending = 1'b0;
  logic [31:0] pend_addr = '0;
  int rd_cnt = 0, overlap_err = 0, done_seen = 0;
  logic [31:0] rd_log [16];

  assign mem_req_ready = (stall_ctr == 0);

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (rst) begin
      pending <= 1'b0;
      stall_ctr <= stall_cfg;
    end else begin
      if (mem_req_valid && mem_req_ready) begin
        pending <= 1'b1;
        pend_addr <= mem_req_addr;
        wait_ctr <= lat_cfg;
        rd_log[rd_cnt % 16] <= mem_req_addr;
        rd_cnt <= rd_cnt + 1;
        stall_ctr <= stall_cfg;
      end else if (mem_req_valid && stall_ctr > 0) begin
        stall_ctr <= stall_ctr - 1;
      end
      if (pending) begin
        if (wait_ctr == 0) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data <= mem_rd(pend_addr);
          pending <= 1'b0;
        end else wait_ctr <= wait_ctr - 1;
      end
    end
  end

  always @(negedge clk) begin
    if (pending && mem_req_valid) overlap_err++;
    if (done) done_seen++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_l1(input logic [31:0] b, input logic [31:0] va);
    return b + (va >> 22) * 4;
  endfunction
  function automatic logic [31:0] exp_l2(input logic [31:0] e1, input logic [31:0] va);
    return (e1 & 32'hFFFF_FFFE) + ((va >> 12) & 32'h3FF) * 4;
  endfunction

  task automatic start_walk(input logic [31:0] va, input logic [31:0] b);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; tbl_base = b;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 busy after accept", {31'b0, busy}, 32'd1);
    check("R2 not ready while busy", {31'b0, req_ready}, 32'd0);
  endtask

  task automatic wait_done(output int ok);
    ok = 0;
    for (int i = 0; i < 200; i++) begin
      if (done) begin ok = 1; break; end
      @(negedge clk);
    end
    check("R9 done seen", ok, 1);
  endtask

  task automatic after_done();
    @(negedge clk);
    check("R9 done one cycle", {31'b0, done}, 32'd0);
    check("R9 idle after done", {31'b0, busy}, 32'd0);
  endtask

  task automatic t_reset();
    check("R1 busy", {31'b0, busy}, 0);
    check("R1 done", {31'b0, done}, 0);
    check("R1 mem_req_valid", {31'b0, mem_req_valid}, 0);
    check("R1 req_ready", {31'b0, req_ready}, 1);
  endtask

  task automatic t_good(input logic [31:0] va, input logic [31:0] b, input logic [31:0] e1,
                        input logic [31:0] e2, input int lat, input int stall);
    int r0, ok;
    lat_cfg = lat; stall_cfg = stall; stall_ctr = stall;
    mem.delete();
    mem[exp_l1(b, va)] = e1;
    mem[exp_l2(e1, va)] = e2;
    r0 = rd_cnt;
    start_walk(va, b);
    wait_done(ok);
    check("R7 fault low", {31'b0, fault}, 0);
    check("R7 paddr", paddr, {e2[31:12], va[11:0]});
    check("R10 two reads", rd_cnt - r0, 2);
    check("R3 first address", rd_log[r0 % 16], exp_l1(b, va));
    check("R5 second address", rd_log[(r0 + 1) % 16], exp_l2(e1, va));
    after_done();
  endtask

  task automatic t_l1_fault();
    int r0, ok;
    logic [31:0] va = 32'h8040_1234, b = 32'h0000_7000;
    lat_cfg = 1; stall_cfg = 0;
    mem.delete();
    mem[exp_l1(b, va)] = 32'h0055_0000;
    r0 = rd_cnt;
    start_walk(va, b);
    wait_done(ok);
    check("R4 fault", {31'b0, fault}, 1);
    check("R4 level", {31'b0, fault_level}, 0);
    check("R4 one read", rd_cnt - r0, 1);
    check("R3 address on fault", rd_log[r0 % 16], exp_l1(b, va));
    after_done();
  endtask

  task automatic t_l2_fault();
    int r0, ok;
    logic [31:0] va = 32'h0ABC_DEF0, b = 32'h0010_0000;
    lat_cfg = 2; stall_cfg = 1;
    mem.delete();
    mem[exp_l1(b, va)] = 32'h0030_0001;
    mem[exp_l2(32'h0030_0001, va)] = 32'hBEEF_0FFE;
    r0 = rd_cnt;
    start_walk(va, b);
    wait_done(ok);
    check("R6 fault", {31'b0, fault}, 1);
    check("R6 level", {31'b0, fault_level}, 1);
    check("R6 two reads", rd_cnt - r0, 2);
    after_done();
  endtask

  task automatic t_busy_ignore();
    int r0, ok;
    logic [31:0] va = 32'h1234_5ABC, b = 32'h0010_0000, e1 = 32'h0020_0001, e2 = 32'hCAFE_0001;
    lat_cfg = 3; stall_cfg = 0;
    mem.delete();
    mem[exp_l1(b, va)] = e1;
    mem[exp_l2(e1, va)] = e2;
    r0 = rd_cnt;
    start_walk(va, b);
    req_valid = 1'b1; req_vaddr = 32'hFFFF_FFFF; tbl_base = 32'h0000_4000;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R2 req_ready low during walk", {31'b0, req_ready}, 0);
    end
    req_valid = 1'b0;
    wait_done(ok);
    check("R2 result from first request", paddr, {e2[31:12], va[11:0]});
    check("R2 second read from first request", rd_log[(r0 + 1) % 16], exp_l2(e1, va));
    after_done();
  endtask

  task automatic t_reset_mid();
    int d0;
    lat_cfg = 8; stall_cfg = 0;
    mem.delete();
    mem[exp_l1(32'h0, 32'h0040_0000)] = 32'h0000_9001;
    start_walk(32'h0040_0000, 32'h0);
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    d0 = done_seen;
    check("R1 busy cleared by reset", {31'b0, busy}, 0);
    check("R1 no request after reset", {31'b0, mem_req_valid}, 0);
    repeat (20) @(negedge clk);
    check("R1 no done after reset", done_seen - d0, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_good(32'h1234_5ABC, 32'h0010_0000, 32'h0020_0001, 32'hCAFE_0001, 0, 0);
    t_good(32'hFFFF_FFFF, 32'h0000_3004, 32'h0080_0401, 32'h7654_3FFF, 4, 3);
    t_good(32'h0000_0000, 32'hFFFF_F000, 32'h0000_0003, 32'h0000_1001, 1, 2);
    t_l1_fault();
    t_l2_fault();
    t_busy_ignore();
    t_reset_mid();
    t_good(32'h7FC0_1800, 32'h0002_0000, 32'h0004_0001, 32'h0ABC_D001, 2, 0);
    check("R8 no request while waiting", overlap_err, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule